// File: doc/BRIEF.md
# Interrupt Pin Trigger and Coalescing Unit

This unit sits between a register block and the interrupt delivery fabric and turns a bank of raw interrupt input lines into single-cycle delivery requests. The register block supplies the per-pin configuration as plain vectors: polarity, trigger mode, mask, vector and destination. For each pin the unit works out whether the line is active, recognises an edge or a level according to the trigger mode, and keeps the request waiting in a per-pin pending bit until it is issued.

Level-triggered pins carry a remote-pending bit. It is set when the pin's request is issued and blocks further requests from that pin until a matching end-of-interrupt message clears it. If the line is still active when the bit clears, the pin requests again. One pin index is given an extra coalescing flag that works the same way in edge mode. When several pins wait at once, one fixed-priority pick issues the lowest index each cycle. The register block can read back the pending and remote-pending bits.

Top module: `irq_trigger_core`

## Requirements
- R1: A pin's line counts as active when the raw input XOR its polarity bit is 1. Polarity 1 makes a low raw input active.
- R2: An edge-mode pin (level bit 0) requests once for each inactive-to-active change of its unmasked line. A line held active makes no further requests, even if an end-of-interrupt carrying that pin's vector arrives meanwhile.
- R3: An edge-mode pin tracks its line level at all times. Rising edges while mask is 1 are dropped, unmasking a line that is already active makes no request, and a fresh rising edge after unmasking requests.
- R4: A level-mode pin (level bit 1) whose line is active while masked requests within two cycles of being unmasked.
- R5: Issuing a request from a level-mode pin sets its remote_pending bit. While the bit is set the pin makes no new request, even though its line stays active.
- R6: An end-of-interrupt whose vector equals a level-mode pin's vector clears that pin's remote_pending bit. If the line is still active, a new request is issued two cycles later. If the line is inactive, no request follows.
- R7: An end-of-interrupt whose vector differs from a pin's vector leaves that pin's remote_pending bit unchanged.
- R8: Switching a pin from level mode to edge mode clears its remote_pending bit on the next clock edge. This acts as an implicit end-of-interrupt.
- R9: The pin at index COAL_PIN (default 8) in edge mode also sets remote_pending on issue. Further edges are coalesced with no request until an end-of-interrupt carrying its vector clears the bit. After that, a fresh edge requests.
- R10: When several unmasked pins are pending, one request is issued per cycle, lowest pin index first. The others stay pending.
- R11: delivery_status[i] is 1 from the clock edge that latches pin i's trigger until the edge that issues it.
- R12: A request is a one-cycle req_valid pulse with req_pin, req_vector and req_dest taken from that pin's configuration. A trigger present before clock edge E appears on the outputs after edge E+1.
- R13: After reset, req_valid, delivery_status and remote_pending are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line | input | NP | Raw interrupt input lines |
| cfg_polarity | input | NP | Per-pin polarity, 1 = active low |
| cfg_level | input | NP | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_mask | input | NP | Per-pin mask, 1 = masked |
| cfg_vector | input | NP*VW | Per-pin vector, pin i at bits [i*VW +: VW] |
| cfg_dest | input | NP*DW | Per-pin destination, pin i at bits [i*DW +: DW] |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VW | Vector carried by the end-of-interrupt |
| req_valid | output | 1 | One-cycle delivery request |
| req_pin | output | PW | Index of the issuing pin |
| req_vector | output | VW | Vector of the issuing pin |
| req_dest | output | DW | Destination of the issuing pin |
| delivery_status | output | NP | Per-pin pending bit |
| remote_pending | output | NP | Per-pin remote-pending bit |

## Verification
The bench uses the default parameters: 24 pins, 8-bit vectors and destinations, and the coalescing pin at index 8. With these values it can reach both ends of the priority chain and the coalescing pin sitting among ordinary edge pins. Random pin subsets of up to 24 simultaneous edges exercise issue ordering across the full width. The 8-bit vectors give every pin a distinct end-of-interrupt vector, so a mismatched vector can be sent without touching another pin.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int DEF_PINS     = 24;
  localparam int DEF_VEC_W    = 8;
  localparam int DEF_DEST_W   = 8;
  localparam int DEF_COAL_PIN = 8;
endpackage

// File: rtl/irq_pin_cell.sv
module irq_pin_cell #(
  parameter bit COALESCE_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic pol,
  input  logic level_mode,
  input  logic mask,
  input  logic eoi_hit,
  input  logic grant,
  output logic pending,
  output logic coal
);
  logic active, prev_active, prev_level, rise, set_req, tracks_coal;

  assign active      = line ^ pol;
  assign rise        = active & ~prev_active;
  assign tracks_coal = level_mode | COALESCE_EDGE;

  always_comb begin
    if (level_mode)
      set_req = active & ~mask & ~coal & ~pending;
    else
      set_req = rise & ~mask & ~(COALESCE_EDGE & coal);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_active <= 1'b0;
      prev_level  <= 1'b0;
      pending     <= 1'b0;
      coal        <= 1'b0;
    end else begin
      prev_active <= active;
      prev_level  <= level_mode;
      if (set_req)
        pending <= 1'b1;
      else if (grant)
        pending <= 1'b0;
      if (grant && tracks_coal)
        coal <= 1'b1;
      else if (eoi_hit && tracks_coal)
        coal <= 1'b0;
      else if (prev_level && !level_mode)
        coal <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NP = 24,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic [NP-1:0] req,
  output logic [NP-1:0] grant,
  output logic          any,
  output logic [PW-1:0] idx
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = PW'(i);
        any = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_grant
    assign grant[g] = any && (idx == PW'(g));
  end
endmodule

// File: rtl/irq_issue_reg.sv
module irq_issue_reg #(
  parameter int PW = 5,
  parameter int VW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [PW-1:0] pin_in,
  input  logic [VW-1:0] vec_in,
  input  logic [DW-1:0] dest_in,
  output logic          req_valid,
  output logic [PW-1:0] req_pin,
  output logic [VW-1:0] req_vector,
  output logic [DW-1:0] req_dest
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_pin    <= '0;
      req_vector <= '0;
      req_dest   <= '0;
    end else begin
      req_valid <= fire;
      if (fire) begin
        req_pin    <= pin_in;
        req_vector <= vec_in;
        req_dest   <= dest_in;
      end
    end
  end
endmodule

// File: rtl/irq_trigger_core.sv
module irq_trigger_core #(
  parameter int NP       = irq_trig_pkg::DEF_PINS,
  parameter int VW       = irq_trig_pkg::DEF_VEC_W,
  parameter int DW       = irq_trig_pkg::DEF_DEST_W,
  parameter int COAL_PIN = irq_trig_pkg::DEF_COAL_PIN,
  localparam int PW      = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    irq_line,
  input  logic [NP-1:0]    cfg_polarity,
  input  logic [NP-1:0]    cfg_level,
  input  logic [NP-1:0]    cfg_mask,
  input  logic [NP*VW-1:0] cfg_vector,
  input  logic [NP*DW-1:0] cfg_dest,
  input  logic             eoi_valid,
  input  logic [VW-1:0]    eoi_vector,
  output logic             req_valid,
  output logic [PW-1:0]    req_pin,
  output logic [VW-1:0]    req_vector,
  output logic [DW-1:0]    req_dest,
  output logic [NP-1:0]    delivery_status,
  output logic [NP-1:0]    remote_pending
);
  logic [NP-1:0] pend, coal, grant, eligible;
  logic          any;
  logic [PW-1:0] sel;
  logic [VW-1:0] sel_vec;
  logic [DW-1:0] sel_dest;

  for (genvar g = 0; g < NP; g++) begin : g_pin
    logic hit;
    assign hit = eoi_valid && (eoi_vector == cfg_vector[g*VW +: VW]);
    irq_pin_cell #(
      .COALESCE_EDGE(g == COAL_PIN)
    ) u_cell (
      .clk       (clk),
      .rst       (rst),
      .line      (irq_line[g]),
      .pol       (cfg_polarity[g]),
      .level_mode(cfg_level[g]),
      .mask      (cfg_mask[g]),
      .eoi_hit   (hit),
      .grant     (grant[g]),
      .pending   (pend[g]),
      .coal      (coal[g])
    );
  end

  assign eligible = pend & ~cfg_mask;

  irq_prio_pick #(.NP(NP)) u_pick (
    .req  (eligible),
    .grant(grant),
    .any  (any),
    .idx  (sel)
  );

  assign sel_vec  = cfg_vector[int'(sel)*VW +: VW];
  assign sel_dest = cfg_dest[int'(sel)*DW +: DW];

  irq_issue_reg #(.PW(PW), .VW(VW), .DW(DW)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .fire      (any),
    .pin_in    (sel),
    .vec_in    (sel_vec),
    .dest_in   (sel_dest),
    .req_valid (req_valid),
    .req_pin   (req_pin),
    .req_vector(req_vector),
    .req_dest  (req_dest)
  );

  assign delivery_status = pend;
  assign remote_pending  = coal;
endmodule

// File: rtl/irq_trigger_sva.sv
module irq_trigger_sva #(
  parameter int NP = 24,
  parameter int VW = 8,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [NP-1:0]    cfg_mask,
  input logic [NP-1:0]    cfg_level,
  input logic [NP*VW-1:0] cfg_vector,
  input logic             req_valid,
  input logic [PW-1:0]    req_pin,
  input logic [VW-1:0]    req_vector,
  input logic [NP-1:0]    delivery_status,
  input logic [NP-1:0]    remote_pending
);
  logic             primed;
  logic [NP-1:0]    q_mask, q_level, q_ds, below;
  logic [NP*VW-1:0] q_vec;
  logic [VW-1:0]    exp_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      q_mask <= '0;
      q_level <= '0;
      q_ds <= '0;
      q_vec <= '0;
    end else begin
      primed <= 1'b1;
      q_mask <= cfg_mask;
      q_level <= cfg_level;
      q_ds <= delivery_status;
      q_vec <= cfg_vector;
    end
  end

  always_comb begin
    for (int i = 0; i < NP; i++) below[i] = (i < int'(req_pin));
    exp_vec = q_vec[int'(req_pin)*VW +: VW];
  end

  AST_MASKED_NEVER_ISSUES: assert property (@(posedge clk) disable iff (rst || !primed)
    req_valid |-> !q_mask[req_pin]); // R3
  AST_VECTOR_FROM_PIN: assert property (@(posedge clk) disable iff (rst || !primed)
    req_valid |-> (req_vector == exp_vec)); // R12
  AST_LEVEL_SETS_REMOTE: assert property (@(posedge clk) disable iff (rst || !primed)
    (req_valid && q_level[req_pin]) |-> remote_pending[req_pin]); // R5
  AST_LOWEST_INDEX_FIRST: assert property (@(posedge clk) disable iff (rst || !primed)
    req_valid |-> ((q_ds & ~q_mask & below) == '0)); // R10
  AST_ISSUE_WAS_PENDING: assert property (@(posedge clk) disable iff (rst || !primed)
    req_valid |-> q_ds[req_pin]); // R11
endmodule

bind irq_trigger_core irq_trigger_sva #(.NP(NP), .VW(VW)) u_sva (
  .clk            (clk),
  .rst            (rst),
  .cfg_mask       (cfg_mask),
  .cfg_level      (cfg_level),
  .cfg_vector     (cfg_vector),
  .req_valid      (req_valid),
  .req_pin        (req_pin),
  .req_vector     (req_vector),
  .delivery_status(delivery_status),
  .remote_pending (remote_pending)
);

// File: tb/sim_irq_trigger_core.sv
`timescale 1ns/1ps
module sim_irq_trigger_core;
  localparam int NP = 24;
  localparam int VW = 8;
  localparam int DW = 8;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] irq_line = '0, cfg_polarity = '0, cfg_level = '0, cfg_mask = '0;
  logic [NP*VW-1:0] cfg_vector;
  logic [NP*DW-1:0] cfg_dest;
  logic eoi_valid = 1'b0;
  logic [VW-1:0] eoi_vector = '0;
  logic req_valid;
  logic [PW-1:0] req_pin;
  logic [VW-1:0] req_vector;
  logic [DW-1:0] req_dest;
  logic [NP-1:0] delivery_status, remote_pending;

  int n_checks = 0, n_fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_trigger_core #(.NP(NP), .VW(VW), .DW(DW), .COAL_PIN(8)) u0 (.*);

  function automatic logic [VW-1:0] vec_of(int p); return VW'(8'h20 + p); endfunction
  function automatic logic [DW-1:0] dest_of(int p); return DW'(8'h40 + p); endfunction

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_req(int p, string tag);
    check(req_valid === 1'b1, {tag, " req_valid"}, req_valid, 1);
    check(req_pin == PW'(p), {tag, " req_pin"}, req_pin, p);
    check(req_vector == vec_of(p), {tag, " req_vector"}, req_vector, vec_of(p));
    check(req_dest == dest_of(p), {tag, " req_dest"}, req_dest, dest_of(p));
  endtask

  task automatic expect_quiet(int n, string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (req_valid) seen++;
    end
    check(seen == 0, {tag, " no request"}, seen, 0);
  endtask

  task automatic pulse_eoi(logic [VW-1:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    step();
    eoi_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] m;
    for (int i = 0; i < NP; i++) begin
      cfg_vector[i*VW +: VW] = vec_of(i);
      cfg_dest[i*DW +: DW] = dest_of(i);
    end
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst = 1'b0;
    step();
    // R13 reset state
    check(req_valid == 1'b0, "R13 req_valid", req_valid, 0);
    check(delivery_status == '0, "R13 delivery_status", delivery_status, 0);
    check(remote_pending == '0, "R13 remote_pending", remote_pending, 0);

    // R2 edge pin 5, held line ignores EOI
    irq_line[5] = 1'b1; step(); step();
    expect_req(5, "R12 R2 first edge");
    pulse_eoi(vec_of(5));
    expect_quiet(4, "R2 held line after EOI");
    irq_line[5] = 1'b0; step();
    irq_line[5] = 1'b1; step(); step();
    expect_req(5, "R2 fresh edge");
    irq_line[5] = 1'b0; step();

    // R3 edge pin 6 with mask
    irq_line[6] = 1'b1; step(); step();
    expect_req(6, "R3 before mask");
    cfg_mask[6] = 1'b1; irq_line[6] = 1'b0; step();
    irq_line[6] = 1'b1; step();
    irq_line[6] = 1'b0; step();
    irq_line[6] = 1'b1;
    expect_quiet(3, "R3 masked edges");
    cfg_mask[6] = 1'b0;
    expect_quiet(4, "R3 unmask with line high");
    irq_line[6] = 1'b0; step();
    irq_line[6] = 1'b1; step(); step();
    expect_req(6, "R3 edge after unmask");
    irq_line[6] = 1'b0; step();

    // R4 level pin 12 active while masked
    cfg_level[12] = 1'b1; cfg_mask[12] = 1'b1; irq_line[12] = 1'b1;
    expect_quiet(4, "R4 masked level");
    cfg_mask[12] = 1'b0; step(); step();
    expect_req(12, "R4 unmask");
    check(remote_pending[12] == 1'b1, "R5 remote after issue", remote_pending[12], 1);
    irq_line[12] = 1'b0; pulse_eoi(vec_of(12));
    check(remote_pending[12] == 1'b0, "R6 eoi clears", remote_pending[12], 0);
    cfg_level[12] = 1'b0; step();

    // R5 R6 R7 level pin 20
    cfg_level[20] = 1'b1; irq_line[20] = 1'b1; step(); step();
    expect_req(20, "R5 level issue");
    check(remote_pending[20] == 1'b1, "R5 remote set", remote_pending[20], 1);
    expect_quiet(4, "R5 coalesced while remote");
    pulse_eoi(8'h99);
    expect_quiet(3, "R7 other vector");
    check(remote_pending[20] == 1'b1, "R7 remote kept", remote_pending[20], 1);
    pulse_eoi(vec_of(20));
    check(remote_pending[20] == 1'b0, "R6 remote cleared", remote_pending[20], 0);
    step(); step();
    expect_req(20, "R6 reinjection");
    irq_line[20] = 1'b0; pulse_eoi(vec_of(20));
    check(remote_pending[20] == 1'b0, "R6 cleared line low", remote_pending[20], 0);
    expect_quiet(3, "R6 no reinject when inactive");

    // R8 implicit EOI by mode change
    irq_line[20] = 1'b1; step(); step();
    expect_req(20, "R8 level issue");
    irq_line[20] = 1'b0; step();
    cfg_level[20] = 1'b0; step();
    check(remote_pending[20] == 1'b0, "R8 mode switch clears", remote_pending[20], 0);
    cfg_level[20] = 1'b1; step();
    irq_line[20] = 1'b1; step(); step();
    expect_req(20, "R8 level again");
    irq_line[20] = 1'b0; pulse_eoi(vec_of(20));
    cfg_level[20] = 1'b0; step();

    // R1 active-low level pin 2
    cfg_polarity[2] = 1'b1; cfg_level[2] = 1'b1; step(); step();
    expect_req(2, "R1 low raw line active");
    irq_line[2] = 1'b1; pulse_eoi(vec_of(2));
    expect_quiet(3, "R1 high raw line inactive");
    cfg_level[2] = 1'b0; step();
    irq_line[2] = 1'b0; cfg_polarity[2] = 1'b0; step();

    // R9 coalescing edge pin 8
    irq_line[8] = 1'b1; step(); step();
    expect_req(8, "R9 first edge");
    check(remote_pending[8] == 1'b1, "R9 flag set", remote_pending[8], 1);
    irq_line[8] = 1'b0; step();
    irq_line[8] = 1'b1;
    expect_quiet(4, "R9 coalesced edge");
    irq_line[8] = 1'b0; step();
    pulse_eoi(vec_of(8));
    check(remote_pending[8] == 1'b0, "R9 eoi clears flag", remote_pending[8], 0);
    irq_line[8] = 1'b1; step(); step();
    expect_req(8, "R9 edge after eoi");
    irq_line[8] = 1'b0; pulse_eoi(vec_of(8)); step();

    // R10 R11 directed priority
    irq_line = (NP'(1) << 3) | (NP'(1) << 10) | (NP'(1) << 15); step();
    check(delivery_status == irq_line, "R11 all pending", delivery_status, irq_line);
    step();
    expect_req(3, "R10 first");
    check(delivery_status == ((NP'(1) << 10) | (NP'(1) << 15)), "R11 issued clears",
          delivery_status, (NP'(1) << 10) | (NP'(1) << 15));
    step(); expect_req(10, "R10 second");
    step(); expect_req(15, "R10 third");
    step();
    check(req_valid == 1'b0, "R10 drained", req_valid, 0);
    irq_line = '0; step();

    // R10 R11 random subsets of edges
    for (int r = 0; r < 20; r++) begin
      m = NP'($urandom);
      if (m == '0) m[0] = 1'b1;
      irq_line = m; step();
      check(delivery_status == m, "R11 random pending", delivery_status, m);
      step();
      for (int p = 0; p < NP; p++) begin
        if (m[p]) begin
          expect_req(p, "R10 random order");
          step();
        end
      end
      check(req_valid == 1'b0, "R10 random drained", req_valid, 0);
      irq_line = '0;
      pulse_eoi(vec_of(8)); step();
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule